// File: doc/BRIEF.md
# Endpoint Event Status and Interrupt Aggregator

This block keeps the event status of four IN endpoints and four OUT endpoints of a device controller. It combines them into one endpoint interrupt word and a single interrupt line. A transfer engine raises one-cycle event pulses on each endpoint, and each pulse is latched into that endpoint's status register. Each endpoint also has a mask register. A set mask bit keeps the matching status bit out of the endpoint's summary bit.

The summary word puts IN endpoints in its lower half and OUT endpoints in its upper half, and it has a mask of its own. A separate register collects device-wide events, such as bus reset or speed enumeration done, and it also has its own mask. Software reads and clears all of this through a small word-addressed register port, and a status bit is cleared by writing a one to it.

The controller has no storage for OUT endpoint 2. Any access to that slot lands on OUT endpoint 0, and OUT endpoint 2 never shows up in the summary.

Top module: `ep_irq_aggregator`

## Requirements
- R1: Each endpoint status register latches six event kinds from its 11-bit event input: OUT data received (bit 4), SETUP received (bit 5), IN token (bit 6), no buffer available (bit 7), bus error (bit 9) and transmit complete (bit 10). A pulse shows in the status on the cycle after the edge that samples it. The other bits always read 0, and pulses on them are ignored.
- R2: A register write to an endpoint status address clears every status bit whose data bit is 1 and leaves the others unchanged. Writing 0xFFFFFFFF clears the whole register.
- R3: When an event pulse and a clearing write hit the same bit on the same edge, the bit ends up set.
- R4: Summary bit i is 1 while IN endpoint i has a status bit set whose mask bit is 0. Summary bit 16+i works the same way for OUT endpoint i. A mask bit of 1 suppresses its status bit. Masks store only the six defined bits. The summary register is read-only, and writes to it are ignored.
- R5: The output ep_irq_word equals the summary with each bit cleared wherever the summary mask holds a 1. Only bits 0-3, 16, 17 and 19 of the summary mask are stored.
- R6: An 8-bit device event register latches set-configuration (bit 0), set-interface (bit 1), early suspend (bit 2), bus reset (bit 3), suspend (bit 4), start of frame (bit 5), enumeration done (bit 6) and status change (bit 7). Its bits are cleared by writing ones, a set wins over a clear on the same edge, and it has its own 8-bit mask.
- R7: irq is high exactly when ep_irq_word is nonzero or some device event bit is set whose mask bit is 0.
- R8: OUT endpoint 2 has no storage of its own. Reads and writes of its status and mask reach OUT endpoint 0, and event pulses on its input set OUT endpoint 0 status. Summary bit 18 is always 0.
- R9: Synchronous active-high reset clears all status and mask registers, so irq and ep_irq_word are 0.
- R10: reg_addr is {region[2:0], index[1:0]}. Region 0 holds IN status, region 1 IN masks, region 2 OUT status and region 3 OUT masks, with the endpoint number as index. Region 4 holds the global registers: index 0 summary, 1 summary mask, 2 device events, 3 device mask. Regions 5 to 7 read 0 and ignore writes. reg_rdata is combinational from reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_evt | input | 44 | IN endpoint event pulses, 11 bits per endpoint, endpoint 0 in the lowest bits |
| out_evt | input | 44 | OUT endpoint event pulses, same layout |
| dev_evt | input | 8 | Device-wide event pulses |
| reg_addr | input | 5 | Register word address |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ep_irq_word | output | 32 | Masked endpoint summary |
| irq | output | 1 | Combined interrupt line |

## Verification
The assertions assume that events and register writes are sampled only at rising clock edges. The clearing property for transmit complete on IN endpoint 0 also assumes that no event pulse lands on that bit in the same cycle, since a pulse would take precedence. The stimulus changes every input half a period away from the rising edge. Its random phase mixes sparse event pulses with clearing and mask writes, including same-cycle conflicts, so every property is exercised under legal timing only.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
    localparam int N_EP          = 4;
    localparam int IDX_W         = $clog2(N_EP);
    localparam int RGN_W         = 3;
    localparam int ADDR_W        = RGN_W + IDX_W;
    localparam int DATA_W        = 32;
    localparam int HALF          = DATA_W / 2;
    localparam int STS_W         = 11;
    localparam int DEV_W         = 8;
    localparam int OUT_ALIAS     = 2;
    localparam int OUT_ALIAS_TGT = 0;

    localparam int B_OUT_DATA = 4;
    localparam int B_SETUP    = 5;
    localparam int B_IN_TOKEN = 6;
    localparam int B_NO_BUF   = 7;
    localparam int B_BUS_ERR  = 9;
    localparam int B_TX_DONE  = 10;

    function automatic logic [STS_W-1:0] sts_valid_bits();
        logic [STS_W-1:0] v;
        v = '0;
        v[B_OUT_DATA] = 1'b1;
        v[B_SETUP]    = 1'b1;
        v[B_IN_TOKEN] = 1'b1;
        v[B_NO_BUF]   = 1'b1;
        v[B_BUS_ERR]  = 1'b1;
        v[B_TX_DONE]  = 1'b1;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] sum_valid_bits();
        logic [DATA_W-1:0] v;
        v = '0;
        for (int i = 0; i < N_EP; i++) begin
            v[i] = 1'b1;
            if (i != OUT_ALIAS) v[HALF+i] = 1'b1;
        end
        return v;
    endfunction

    localparam logic [STS_W-1:0]  STS_VALID = sts_valid_bits();
    localparam logic [DATA_W-1:0] SUM_VALID = sum_valid_bits();

    typedef enum logic [RGN_W-1:0] {
        RG_IN_STS  = 3'd0,
        RG_IN_MSK  = 3'd1,
        RG_OUT_STS = 3'd2,
        RG_OUT_MSK = 3'd3,
        RG_GLOBAL  = 3'd4
    } region_e;

    localparam logic [IDX_W-1:0] G_SUM    = IDX_W'(0);
    localparam logic [IDX_W-1:0] G_SUMMSK = IDX_W'(1);
    localparam logic [IDX_W-1:0] G_DEV    = IDX_W'(2);
    localparam logic [IDX_W-1:0] G_DEVMSK = IDX_W'(3);

    typedef logic [N_EP-1:0][STS_W-1:0] ep_sts_arr_t;

    function automatic logic [IDX_W-1:0] out_phys(input logic [IDX_W-1:0] ix);
        return (ix == IDX_W'(OUT_ALIAS)) ? IDX_W'(OUT_ALIAS_TGT) : ix;
    endfunction
endpackage

// File: rtl/ep_evt_slot.sv
module ep_evt_slot #(
    parameter int             W     = 11,
    parameter logic [W-1:0]   VALID = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         sts_wr_i,
    input  logic         msk_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] sts_o,
    output logic [W-1:0] msk_o,
    output logic         pend_o
);
    logic [W-1:0] sts_q, msk_q, clr;

    assign clr = sts_wr_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            msk_q <= '0;
        end else begin
            sts_q <= ((sts_q & ~clr) | set_i) & VALID;
            if (msk_wr_i) msk_q <= wdata_i & VALID;
        end
    end

    assign sts_o  = sts_q;
    assign msk_o  = msk_q;
    assign pend_o = |(sts_q & ~msk_q);
endmodule

// File: rtl/ep_reg_readmux.sv
module ep_reg_readmux
    import ep_irq_pkg::*;
(
    input  region_e              rg,
    input  logic [IDX_W-1:0]     ix,
    input  ep_sts_arr_t          in_sts,
    input  ep_sts_arr_t          in_msk,
    input  ep_sts_arr_t          out_sts,
    input  ep_sts_arr_t          out_msk,
    input  logic [DATA_W-1:0]    summary,
    input  logic [DATA_W-1:0]    sum_msk,
    input  logic [DEV_W-1:0]     dev_sts,
    input  logic [DEV_W-1:0]     dev_msk,
    output logic [DATA_W-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        case (rg)
            RG_IN_STS:  rdata = DATA_W'(in_sts[ix]);
            RG_IN_MSK:  rdata = DATA_W'(in_msk[ix]);
            RG_OUT_STS: rdata = DATA_W'(out_sts[out_phys(ix)]);
            RG_OUT_MSK: rdata = DATA_W'(out_msk[out_phys(ix)]);
            RG_GLOBAL: begin
                case (ix)
                    G_SUM:    rdata = summary;
                    G_SUMMSK: rdata = sum_msk;
                    G_DEV:    rdata = DATA_W'(dev_sts);
                    G_DEVMSK: rdata = DATA_W'(dev_msk);
                    default:  rdata = '0;
                endcase
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ep_irq_aggregator.sv
module ep_irq_aggregator
    import ep_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_EP*STS_W-1:0]   in_evt,
    input  logic [N_EP*STS_W-1:0]   out_evt,
    input  logic [DEV_W-1:0]        dev_evt,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic [DATA_W-1:0]       ep_irq_word,
    output logic                    irq
);
    region_e          rg;
    logic [IDX_W-1:0] ix;
    logic [IDX_W-1:0] out_ix;

    assign rg     = region_e'(reg_addr[ADDR_W-1:IDX_W]);
    assign ix     = reg_addr[IDX_W-1:0];
    assign out_ix = out_phys(ix);

    ep_sts_arr_t     in_sts_p, in_msk_p, out_sts_p, out_msk_p;
    logic [N_EP-1:0] in_pend, out_pend;

    for (genvar i = 0; i < N_EP; i++) begin : g_in
        ep_evt_slot #(.W(STS_W), .VALID(STS_VALID)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .set_i    (in_evt[i*STS_W +: STS_W]),
            .sts_wr_i (reg_wr && rg == RG_IN_STS && ix == IDX_W'(i)),
            .msk_wr_i (reg_wr && rg == RG_IN_MSK && ix == IDX_W'(i)),
            .wdata_i  (reg_wdata[STS_W-1:0]),
            .sts_o    (in_sts_p[i]),
            .msk_o    (in_msk_p[i]),
            .pend_o   (in_pend[i])
        );
    end

    for (genvar i = 0; i < N_EP; i++) begin : g_out
        if (i == OUT_ALIAS) begin : g_alias
            assign out_sts_p[i] = '0;
            assign out_msk_p[i] = '0;
            assign out_pend[i]  = 1'b0;
        end else begin : g_store
            logic [STS_W-1:0] set_w;
            if (i == OUT_ALIAS_TGT) begin : g_merge
                assign set_w = out_evt[i*STS_W +: STS_W] | out_evt[OUT_ALIAS*STS_W +: STS_W];
            end else begin : g_own
                assign set_w = out_evt[i*STS_W +: STS_W];
            end
            ep_evt_slot #(.W(STS_W), .VALID(STS_VALID)) u_slot (
                .clk      (clk),
                .rst      (rst),
                .set_i    (set_w),
                .sts_wr_i (reg_wr && rg == RG_OUT_STS && out_ix == IDX_W'(i)),
                .msk_wr_i (reg_wr && rg == RG_OUT_MSK && out_ix == IDX_W'(i)),
                .wdata_i  (reg_wdata[STS_W-1:0]),
                .sts_o    (out_sts_p[i]),
                .msk_o    (out_msk_p[i]),
                .pend_o   (out_pend[i])
            );
        end
    end

    logic [DEV_W-1:0] dev_sts, dev_msk;
    logic             dev_pend;

    ep_evt_slot #(.W(DEV_W), .VALID('1)) u_dev (
        .clk      (clk),
        .rst      (rst),
        .set_i    (dev_evt),
        .sts_wr_i (reg_wr && rg == RG_GLOBAL && ix == G_DEV),
        .msk_wr_i (reg_wr && rg == RG_GLOBAL && ix == G_DEVMSK),
        .wdata_i  (reg_wdata[DEV_W-1:0]),
        .sts_o    (dev_sts),
        .msk_o    (dev_msk),
        .pend_o   (dev_pend)
    );

    logic [DATA_W-1:0] summary, sum_msk_q;

    always_comb begin
        summary = '0;
        for (int i = 0; i < N_EP; i++) begin
            summary[i]      = in_pend[i];
            summary[HALF+i] = out_pend[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sum_msk_q <= '0;
        else if (reg_wr && rg == RG_GLOBAL && ix == G_SUMMSK)
            sum_msk_q <= reg_wdata & SUM_VALID;
    end

    assign ep_irq_word = summary & ~sum_msk_q;
    assign irq         = (|ep_irq_word) | dev_pend;

    ep_reg_readmux u_rd (
        .rg      (rg),
        .ix      (ix),
        .in_sts  (in_sts_p),
        .in_msk  (in_msk_p),
        .out_sts (out_sts_p),
        .out_msk (out_msk_p),
        .summary (summary),
        .sum_msk (sum_msk_q),
        .dev_sts (dev_sts),
        .dev_msk (dev_msk),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/ep_irq_aggregator_chk.sv
module ep_irq_aggregator_chk
    import ep_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ev_done,
    input logic              sts_done,
    input logic              clr_done,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-1:0] ep_irq_word,
    input logic [DATA_W-1:0] sum_msk,
    input logic              irq
);
    // R3 (and R1): a pulse on IN0 transmit-complete is always latched
    a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
        ev_done |=> sts_done);

    // R2: a clearing write without a competing pulse empties the bit
    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(0) && clr_done && !ev_done) |=> !sts_done);

    // R1: undefined status bits never read back as 1
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[ADDR_W-1:IDX_W] == RGN_W'(RG_IN_STS) ||
         reg_addr[ADDR_W-1:IDX_W] == RGN_W'(RG_OUT_STS))
        |-> ((reg_rdata & ~DATA_W'(STS_VALID)) == '0));

    // R5: masked summary bits stay quiet
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (ep_irq_word & sum_msk) == '0);

    // R8: the aliased OUT slot never reports
    a_r8_alias_silent: assert property (@(posedge clk) disable iff (rst)
        !ep_irq_word[HALF+OUT_ALIAS]);

    // R7: any pending endpoint bit drives the line
    a_r7_word_raises_irq: assert property (@(posedge clk) disable iff (rst)
        (|ep_irq_word) |-> irq);

    // R9: line is low right after reset
    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);
endmodule

bind ep_irq_aggregator ep_irq_aggregator_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_done     (in_evt[ep_irq_pkg::B_TX_DONE]),
    .sts_done    (in_sts_p[0][ep_irq_pkg::B_TX_DONE]),
    .clr_done    (reg_wdata[ep_irq_pkg::B_TX_DONE]),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .ep_irq_word (ep_irq_word),
    .sum_msk     (sum_msk_q),
    .irq         (irq)
);

// File: tb/ep_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module ep_irq_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [43:0] in_evt = '0, out_evt = '0;
    logic [7:0]  dev_evt = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, ep_irq_word;
    logic        irq;

    always #2 clk = ~clk;

    ep_irq_aggregator dut_i (
        .clk(clk), .rst(rst), .in_evt(in_evt), .out_evt(out_evt), .dev_evt(dev_evt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ep_irq_word(ep_irq_word), .irq(irq)
    );

    // behavioural reference state
    int unsigned m_in_s[4], m_in_m[4], m_out_s[4], m_out_m[4];
    int unsigned m_sm, m_dv, m_dm;
    logic        p_rst = 1'b1, p_w = 1'b0;
    logic [4:0]  p_a = '0;
    logic [31:0] p_d = '0;
    logic [43:0] p_ie = '0, p_oe = '0;
    logic [7:0]  p_de = '0;
    int n_vec = 0, n_fail = 0;
    bit done = 0;

    localparam int unsigned VALID = 32'h6F0;
    localparam int unsigned SUMV  = 32'h000B000F;

    function automatic int unsigned pick(logic [43:0] v, int ep);
        return 32'(v[ep*11 +: 11]);
    endfunction

    function automatic logic [4:0] A(int rg, int ix);
        return 5'(rg*4 + ix);
    endfunction

    function automatic logic [43:0] E(int ep, int b);
        return 44'(1) << (ep*11 + b);
    endfunction

    function automatic int unsigned m_sum();
        int unsigned s = 0;
        for (int i = 0; i < 4; i++) begin
            if ((m_in_s[i] & ~m_in_m[i]) != 0) s |= (32'd1 << i);
            if (i != 2 && (m_out_s[i] & ~m_out_m[i]) != 0) s |= (32'd1 << (16+i));
        end
        return s;
    endfunction

    function automatic int unsigned m_read(logic [4:0] a);
        int rg = int'(a) >> 2;
        int ix = int'(a) & 3;
        int px = (ix == 2) ? 0 : ix;
        case (rg)
            0: return m_in_s[ix];
            1: return m_in_m[ix];
            2: return m_out_s[px];
            3: return m_out_m[px];
            4: case (ix)
                   0: return m_sum();
                   1: return m_sm;
                   2: return m_dv;
                   default: return m_dm;
               endcase
            default: return 0;
        endcase
    endfunction

    task automatic commit();
        int rg = int'(p_a) >> 2;
        int ix = int'(p_a) & 3;
        int px = (ix == 2) ? 0 : ix;
        if (p_rst) begin
            for (int i = 0; i < 4; i++) begin
                m_in_s[i] = 0; m_in_m[i] = 0; m_out_s[i] = 0; m_out_m[i] = 0;
            end
            m_sm = 0; m_dv = 0; m_dm = 0;
            return;
        end
        for (int i = 0; i < 4; i++) begin
            int unsigned clr = (p_w && rg == 0 && ix == i) ? p_d : 0;
            m_in_s[i] = ((m_in_s[i] & ~clr) | pick(p_ie, i)) & VALID;
            if (p_w && rg == 1 && ix == i) m_in_m[i] = p_d & VALID;
        end
        for (int i = 0; i < 4; i++) begin
            if (i != 2) begin
                int unsigned clr = (p_w && rg == 2 && px == i) ? p_d : 0;
                int unsigned ev  = pick(p_oe, i) | ((i == 0) ? pick(p_oe, 2) : 0);
                m_out_s[i] = ((m_out_s[i] & ~clr) | ev) & VALID;
                if (p_w && rg == 3 && px == i) m_out_m[i] = p_d & VALID;
            end
        end
        if (p_w && rg == 4 && ix == 1) m_sm = p_d & SUMV;
        m_dv = ((m_dv & ~((p_w && rg == 4 && ix == 2) ? p_d : 0)) | 32'(p_de)) & 32'hFF;
        if (p_w && rg == 4 && ix == 3) m_dm = p_d & 32'hFF;
    endtask

    task automatic compare(string tag);
        int unsigned e_rd  = m_read(reg_addr);
        int unsigned e_wd  = m_sum() & ~m_sm;
        logic        e_irq = (e_wd != 0) || ((m_dv & ~m_dm) != 0);
        bit bad = 0;
        n_vec++;
        if (reg_rdata !== e_rd) begin
            bad = 1;
            $display("FAIL %s reg_rdata addr=%0h actual=%08h expected=%08h", tag, reg_addr, reg_rdata, e_rd);
        end
        if (ep_irq_word !== e_wd) begin
            bad = 1;
            $display("FAIL %s ep_irq_word actual=%08h expected=%08h", tag, ep_irq_word, e_wd);
        end
        if (irq !== e_irq) begin
            bad = 1;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e_irq);
        end
        if (bad) n_fail++;
    endtask

    task automatic step(string tag, logic r, logic [4:0] a, logic w, logic [31:0] d,
                        logic [43:0] ie, logic [43:0] oe, logic [7:0] de);
        @(negedge clk);
        commit();
        rst = r; reg_addr = a; reg_wr = w; reg_wdata = d;
        in_evt = ie; out_evt = oe; dev_evt = de;
        #1;
        compare(tag);
        p_rst = r; p_a = a; p_w = w; p_d = d; p_ie = ie; p_oe = oe; p_de = de;
    endtask

    task automatic rd(string tag, logic [4:0] a);
        step(tag, 1'b0, a, 1'b0, 32'h0, '0, '0, 8'h0);
    endtask

    task automatic wr(string tag, logic [4:0] a, logic [31:0] d);
        step(tag, 1'b0, a, 1'b1, d, '0, '0, 8'h0);
    endtask

    task automatic ev(string tag, logic [4:0] a, logic [43:0] ie, logic [43:0] oe, logic [7:0] de);
        step(tag, 1'b0, a, 1'b0, 32'h0, ie, oe, de);
    endtask

    initial begin
        // R9: reset state
        for (int k = 0; k < 3; k++) step("R9", 1'b1, A(4,0), 1'b0, 32'h0, '0, '0, 8'h0);
        rd("R9", A(4,0));
        rd("R9", A(0,0));

        // R1: each defined bit latches; reserved bits ignored
        ev("R1", A(0,1), E(1,4) | E(1,10) | E(1,0) | E(1,8), '0, 8'h0);
        rd("R1", A(0,1));
        ev("R1", A(2,3), '0, E(3,5) | E(3,6) | E(3,7) | E(3,9) | E(3,3), 8'h0);
        rd("R1", A(2,3));

        // R2: partial clear, then clear-all
        wr("R2", A(0,1), 32'h0000_0010);
        rd("R2", A(0,1));
        wr("R2", A(2,3), 32'hFFFF_FFFF);
        rd("R2", A(2,3));
        wr("R2", A(0,1), 32'hFFFF_FFFF);
        rd("R2", A(0,1));

        // R3: set and clear on the same edge
        step("R3", 1'b0, A(0,0), 1'b1, 32'hFFFF_FFFF, E(0,10) | E(0,4), '0, 8'h0);
        rd("R3", A(0,0));
        wr("R3", A(0,0), 32'hFFFF_FFFF);
        rd("R3", A(0,0));

        // R4: endpoint mask suppresses summary; summary writes ignored
        wr("R4", A(1,2), 32'hFFFF_FFFF);
        rd("R4", A(1,2));
        ev("R4", A(4,0), E(2,7), E(1,9), 8'h0);
        rd("R4", A(4,0));
        wr("R4", A(4,0), 32'h0000_0000);
        rd("R4", A(4,0));
        wr("R4", A(1,2), 32'h0000_0000);
        rd("R4", A(4,0));

        // R5: summary mask
        wr("R5", A(4,1), 32'hFFFF_FFFF);
        rd("R5", A(4,1));
        wr("R5", A(4,1), 32'h0002_0004);
        rd("R5", A(4,0));
        wr("R5", A(4,1), 32'h0);
        wr("R5", A(0,2), 32'hFFFF_FFFF);
        wr("R5", A(2,1), 32'hFFFF_FFFF);
        rd("R5", A(4,0));

        // R6: device events, clear with set-wins, mask
        ev("R6", A(4,2), '0, '0, 8'hA5);
        rd("R6", A(4,2));
        step("R6", 1'b0, A(4,2), 1'b1, 32'hFF, '0, '0, 8'h01);
        rd("R6", A(4,2));
        wr("R6", A(4,3), 32'hFFFF_FF01);
        rd("R6", A(4,3));

        // R7: line follows unmasked device and endpoint pending
        wr("R7", A(4,3), 32'h0);
        rd("R7", A(4,0));
        wr("R7", A(4,2), 32'hFF);
        rd("R7", A(4,0));

        // R8: OUT endpoint 2 aliases OUT endpoint 0
        ev("R8", A(2,2), '0, E(2,4), 8'h0);
        rd("R8", A(2,0));
        rd("R8", A(4,0));
        wr("R8", A(3,2), 32'h0000_0010);
        rd("R8", A(3,0));
        rd("R8", A(4,0));
        wr("R8", A(2,2), 32'hFFFF_FFFF);
        rd("R8", A(2,0));
        wr("R8", A(3,0), 32'h0);

        // R10: unmapped regions read zero and ignore writes
        ev("R10", A(5,0), E(3,10), '0, 8'h0);
        wr("R10", A(6,3), 32'hFFFF_FFFF);
        rd("R10", A(7,1));
        rd("R10", A(0,3));
        wr("R10", A(5,3), 32'hFFFF_FFFF);
        rd("R10", A(0,3));

        // R7: random mix of pulses, clears and mask writes, compared every clock
        for (int n = 0; n < 4000; n++) begin
            logic [43:0] ie, oe;
            logic [31:0] d;
            logic        w;
            for (int e = 0; e < 4; e++) begin
                ie[e*11 +: 11] = 11'($urandom & $urandom & $urandom);
                oe[e*11 +: 11] = 11'($urandom & $urandom & $urandom);
            end
            w = ($urandom % 3) == 0;
            d = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
            step("R7", 1'b0, 5'($urandom), w, d, ie, oe, 8'($urandom & $urandom & $urandom));
        end
        for (int k = 0; k < 2; k++) step("R9", 1'b1, A(4,0), 1'b0, 32'h0, '0, '0, 8'h0);
        rd("R9", A(4,0));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule